// File: doc/BRIEF.md
# Linked-Descriptor Transfer Sequencer

This block lets a 2D DMA engine run a whole chain of transfers without software touching registers between them. Software stores a linked list of transfer descriptors in memory, puts the address of the first one in a register, turns on descriptor mode and submits. The block reads each descriptor word by word over a read-only memory port. It hands the transfer described there to the data mover and waits for that transfer to finish. It then either follows the descriptor's next pointer or stops.

Each completion is reported with the descriptor's id. A descriptor can ask for an interrupt, which stays pending until software clears it. A bad memory read while a descriptor is being fetched aborts the chain and flags an error. Both the memory request and the transfer request are valid/ready channels. The block keeps a channel's valid and its payload unchanged until the other side raises ready, and it never withdraws a request once offered. Memory responses, the transfer-done pulse and the register port have no back-pressure.

Top module: `sg_desc_fetch`

## Requirements
- R1: After reset no memory request, transfer request, completion or interrupt is driven, and the status register (0x408) reads 0.
- R2: A chain starts only on a write of 1 in bit 0 of the submit register (0x404), and only while bit 0 of the control register (0x400) is set and the block is idle. A submit with that bit clear, or a submit while busy, issues no memory request.
- R3: A descriptor is twelve 32-bit words at base+4k. In word order they are flags, id, destination low/high, source low/high, next low/high, y length, x length, source stride and destination stride. Only one read is outstanding at a time, and an unaccepted memory request keeps its address.
- R4: The transfer request carries destination, source, x length (byte count minus one, passed unchanged), y length (0 for 1D), both strides and the id. An unaccepted request keeps all of these stable.
- R5: No word of the next descriptor is requested between acceptance of a transfer and its done pulse.
- R6: Flags bit 0 set ends the chain after that transfer, and its next pointer is never followed. Clear means the descriptor at the next address is fetched.
- R7: The cycle after a done pulse, the completion output pulses for one cycle with that descriptor's id. The id is also held in the last-id register (0x40C).
- R8: Flags bit 1 set makes the interrupt output and status bit 2 go high the cycle after the completion pulse. They stay high until 1 is written to status bit 2. Descriptors without the flag leave them unchanged.
- R9: A memory read error during a fetch issues no transfer, returns the block to idle and sets status bit 1. Writing 1 to that bit clears it.
- R10: The cyclic-mode output follows control bit 1 only while control bit 0 is clear.
- R11: Status bit 0 reads 1 from submit until the chain ends or aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 12 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 12 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read word |
| mem_rsp_err | input | 1 | Read failed |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Data mover accepts request |
| xfer_dst | output | ADDR_W | Destination address |
| xfer_src | output | ADDR_W | Source address |
| xfer_x_len | output | 32 | Bytes per row minus one |
| xfer_y_len | output | 32 | Row count field |
| xfer_src_stride | output | 32 | Source row stride |
| xfer_dst_stride | output | 32 | Destination row stride |
| xfer_id | output | 32 | Descriptor id |
| xfer_done | input | 1 | Accepted transfer finished (one-cycle pulse) |
| cpl_valid | output | 1 | Completion pulse |
| cpl_id | output | 32 | Id of completed descriptor |
| irq | output | 1 | Pending end-of-transfer interrupt |
| cyclic_en | output | 1 | Cyclic mode enable for the data mover |

## Verification
The assertions take for granted that the memory returns exactly one response per accepted request and never a response unasked. They also take for granted that `xfer_done` pulses only for a transfer that has been accepted and not yet finished. The memory and data-mover models in the bench follow these rules by construction. The memory model keeps one pending read and answers it on the next cycle. The mover model arms its done pulse only on an accepted request and fires it once after a fixed delay. Both models can toggle ready every cycle so that back-pressure holds a request across edges.

// File: rtl/sgdf_pkg.sv
package sgdf_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 12;
  localparam int RAW_W     = WORD_W * NUM_WORDS;
  localparam int REG_AW    = 12;

  localparam logic [REG_AW-1:0] OFS_CTRL     = 12'h400;
  localparam logic [REG_AW-1:0] OFS_SUBMIT   = 12'h404;
  localparam logic [REG_AW-1:0] OFS_STATUS   = 12'h408;
  localparam logic [REG_AW-1:0] OFS_LAST_ID  = 12'h40C;
  localparam logic [REG_AW-1:0] OFS_FIRST_LO = 12'h47C;
  localparam logic [REG_AW-1:0] OFS_FIRST_HI = 12'h480;

  // Word 0 sits at the least significant end, so the last field listed is word 0.
  typedef struct packed {
    logic [31:0] dst_stride;
    logic [31:0] src_stride;
    logic [31:0] x_len;
    logic [31:0] y_len;
    logic [63:0] next;
    logic [63:0] src;
    logic [63:0] dst;
    logic [31:0] id;
    logic [31:0] flags;
  } desc_t;
endpackage

// File: rtl/sgdf_regs.sv
module sgdf_regs
  import sgdf_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [31:0]       wdata,
  input  logic [REG_AW-1:0] raddr,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              err_set,
  input  logic              irq_set,
  input  logic              cpl_valid,
  input  logic [31:0]       cpl_id,
  output logic              go,
  output logic [ADDR_W-1:0] first_addr,
  output logic              irq,
  output logic              cyclic_en
);
  logic        hw_mode, cyc_req, err_q, irq_q;
  logic [63:0] first_q;
  logic [31:0] last_id_q;
  logic        wr_stat;

  assign wr_stat    = we && (waddr == OFS_STATUS);
  assign go         = we && (waddr == OFS_SUBMIT) && wdata[0] && hw_mode;
  assign first_addr = first_q[ADDR_W-1:0];
  assign irq        = irq_q;
  assign cyclic_en  = cyc_req && !hw_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_mode   <= 1'b0;
      cyc_req   <= 1'b0;
      err_q     <= 1'b0;
      irq_q     <= 1'b0;
      first_q   <= '0;
      last_id_q <= '0;
    end else begin
      if (we && waddr == OFS_CTRL) begin
        hw_mode <= wdata[0];
        cyc_req <= wdata[1];
      end
      if (we && waddr == OFS_FIRST_LO) first_q[31:0]  <= wdata;
      if (we && waddr == OFS_FIRST_HI) first_q[63:32] <= wdata;
      // a set in the same cycle as a clear wins
      if (err_set)                     err_q <= 1'b1;
      else if (wr_stat && wdata[1])    err_q <= 1'b0;
      if (irq_set)                     irq_q <= 1'b1;
      else if (wr_stat && wdata[2])    irq_q <= 1'b0;
      if (cpl_valid)                   last_id_q <= cpl_id;
    end
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      OFS_CTRL:     rdata = {30'd0, cyc_req, hw_mode};
      OFS_STATUS:   rdata = {29'd0, irq_q, err_q, busy};
      OFS_LAST_ID:  rdata = last_id_q;
      OFS_FIRST_LO: rdata = first_q[31:0];
      OFS_FIRST_HI: rdata = first_q[63:32];
      default:      rdata = '0;
    endcase
  end

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(wr_stat && wdata[2]) |=> irq);
endmodule

// File: rtl/sgdf_fetch.sv
module sgdf_fetch
  import sgdf_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              desc_done,
  output logic              fetch_err,
  output desc_t             desc
);
  localparam int CNT_W = $clog2(NUM_WORDS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_WORDS - 1);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_t;
  fst_t              st;
  logic [CNT_W-1:0]  idx;
  logic [ADDR_W-1:0] base;
  logic [RAW_W-1:0]  raw;

  assign mem_req_valid = (st == F_REQ);
  assign mem_req_addr  = base + {{(ADDR_W-CNT_W-2){1'b0}}, idx, 2'b00};
  assign desc          = desc_t'(raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= F_IDLE;
      idx       <= '0;
      base      <= '0;
      raw       <= '0;
      desc_done <= 1'b0;
      fetch_err <= 1'b0;
    end else begin
      desc_done <= 1'b0;
      fetch_err <= 1'b0;
      case (st)
        F_IDLE: if (start) begin
          base <= start_addr;
          idx  <= '0;
          st   <= F_REQ;
        end
        F_REQ: if (mem_req_ready) st <= F_WAIT;
        F_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            fetch_err <= 1'b1;
            st        <= F_IDLE;
          end else begin
            raw[idx*WORD_W +: WORD_W] <= mem_rsp_data;
            if (idx == LAST_IDX) begin
              desc_done <= 1'b1;
              st        <= F_IDLE;
            end else begin
              idx <= idx + 1'b1;
              st  <= F_REQ;
            end
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> st == F_IDLE);
endmodule

// File: rtl/sgdf_seq.sv
module sgdf_seq
  import sgdf_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic              last,
  input  logic              irq_req,
  input  logic [31:0]       id,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic              desc_done,
  input  logic              fetch_err,
  input  logic              xfer_ready,
  input  logic              xfer_done,
  output logic              fetch_start,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              xfer_valid,
  output logic              cpl_valid,
  output logic [31:0]       cpl_id,
  output logic              irq_set,
  output logic              err_set,
  output logic              busy
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ISSUE, S_WAIT} sst_t;
  sst_t st;

  always_comb begin
    fetch_start = (st == S_IDLE && go) || (st == S_WAIT && xfer_done && !last);
    fetch_addr  = (st == S_IDLE) ? first_addr : next_addr;
    err_set     = (st == S_FETCH) && fetch_err;
    xfer_valid  = (st == S_ISSUE);
    busy        = (st != S_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cpl_valid <= 1'b0;
      cpl_id    <= '0;
      irq_set   <= 1'b0;
    end else begin
      cpl_valid <= 1'b0;
      irq_set   <= 1'b0;
      case (st)
        S_IDLE:  if (go) st <= S_FETCH;
        S_FETCH: begin
          if (fetch_err)      st <= S_IDLE;
          else if (desc_done) st <= S_ISSUE;
        end
        S_ISSUE: if (xfer_ready) st <= S_WAIT;
        S_WAIT: if (xfer_done) begin
          cpl_valid <= 1'b1;
          cpl_id    <= id;
          irq_set   <= irq_req;
          st        <= last ? S_IDLE : S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_cpl_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> $past(xfer_done));
endmodule

// File: rtl/sg_desc_fetch.sv
module sg_desc_fetch
  import sgdf_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [11:0]       reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [11:0]       reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_dst,
  output logic [ADDR_W-1:0] xfer_src,
  output logic [31:0]       xfer_x_len,
  output logic [31:0]       xfer_y_len,
  output logic [31:0]       xfer_src_stride,
  output logic [31:0]       xfer_dst_stride,
  output logic [31:0]       xfer_id,
  input  logic              xfer_done,
  output logic              cpl_valid,
  output logic [31:0]       cpl_id,
  output logic              irq,
  output logic              cyclic_en
);
  desc_t             desc;
  logic              go, busy, err_set, irq_set;
  logic              fetch_start, desc_done, fetch_err;
  logic [ADDR_W-1:0] first_addr, fetch_addr;

  sgdf_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .busy, .err_set, .irq_set,
    .cpl_valid, .cpl_id, .go, .first_addr, .irq, .cyclic_en
  );

  sgdf_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk, .rst_n, .start(fetch_start), .start_addr(fetch_addr),
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_data, .mem_rsp_err,
    .desc_done, .fetch_err, .desc
  );

  sgdf_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .go, .first_addr,
    .last(desc.flags[0]), .irq_req(desc.flags[1]), .id(desc.id),
    .next_addr(desc.next[ADDR_W-1:0]), .desc_done, .fetch_err,
    .xfer_ready, .xfer_done, .fetch_start, .fetch_addr, .xfer_valid,
    .cpl_valid, .cpl_id, .irq_set, .err_set, .busy
  );

  assign xfer_dst        = desc.dst[ADDR_W-1:0];
  assign xfer_src        = desc.src[ADDR_W-1:0];
  assign xfer_x_len      = desc.x_len;
  assign xfer_y_len      = desc.y_len;
  assign xfer_src_stride = desc.src_stride;
  assign xfer_dst_stride = desc.dst_stride;
  assign xfer_id         = desc.id;

  // checker state: a transfer has been accepted and its done pulse is still due
  logic in_flight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        in_flight <= 1'b0;
    else if (xfer_valid && xfer_ready) in_flight <= 1'b1;
    else if (xfer_done)                in_flight <= 1'b0;
  end

  a_r5_quiet_while_moving: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !mem_req_valid);
  a_r4_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_id) &&
      $stable(xfer_dst) && $stable(xfer_src) && $stable(xfer_x_len));
  a_r8_irq_after_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cpl_valid));
  a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |=> !busy && !xfer_valid);
endmodule

// File: tb/sg_desc_fetch_bench.sv
`timescale 1ns/1ps
module sg_desc_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req_valid, mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        xfer_valid, xfer_ready = 1'b1, xfer_done = 1'b0;
  logic [63:0] xfer_dst, xfer_src;
  logic [31:0] xfer_x_len, xfer_y_len, xfer_src_stride, xfer_dst_stride, xfer_id;
  logic        cpl_valid, irq, cyclic_en;
  logic [31:0] cpl_id;

  always #2.5 clk = ~clk;

  sg_desc_fetch u_sg_desc_fetch (.*);

  typedef struct packed {
    logic [1:0]  flags;
    logic [31:0] id;
    logic [63:0] dst, src;
    logic [31:0] y, x, ss, ds;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{2'b10, 32'h11, 64'h0000_0001_0000_1000, 64'h0000_0002_0000_2000, 32'd0, 32'hFF,  32'd0,     32'd0},
    '{2'b00, 32'h22, 64'h0000_0000_0000_4000, 64'hABCD_0000_0000_5000, 32'd3, 32'h3F,  32'h100,   32'h80},
    '{2'b00, 32'h33, 64'h8000_0000_0000_0010, 64'h0000_0000_0000_0020, 32'd0, 32'd0,   32'd0,     32'd0},
    '{2'b01, 32'h44, 64'h0000_0003_0000_6000, 64'h0000_0004_0000_7000, 32'd1, 32'h7FF, 32'h1000,  32'h2000}
  };
  localparam int DLY = 20;

  int checks = 0, errors = 0;
  logic [31:0] mem [64];
  int err_word = -1, reqs = 0, reqs_acc = 0, viol = 0, nx = 0, ncpl = 0, dcnt = 0;
  bit stall = 0;
  logic [63:0] g_dst[8], g_src[8];
  logic [31:0] g_x[8], g_y[8], g_ss[8], g_ds[8], g_id[8], c_id[8];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_raddr = a; #0.1; v = reg_rdata;
  endtask

  task automatic load_desc(input int w, input vec_t v, input logic [63:0] nxt);
    mem[w+0]  = {30'd0, v.flags}; mem[w+1] = v.id;
    mem[w+2]  = v.dst[31:0];  mem[w+3] = v.dst[63:32];
    mem[w+4]  = v.src[31:0];  mem[w+5] = v.src[63:32];
    mem[w+6]  = nxt[31:0];    mem[w+7] = nxt[63:32];
    mem[w+8]  = v.y; mem[w+9] = v.x; mem[w+10] = v.ss; mem[w+11] = v.ds;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); rd(12'h408, s);
      if (!s[0]) break;
    end
  endtask

  // memory model: one pending read, answered on the following cycle
  initial begin
    int pidx;
    bit pend;
    pend = 0; pidx = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = mem[pidx];
        mem_rsp_err = (pidx == err_word); pend = 0;
      end
      mem_req_ready = stall ? ~mem_req_ready : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1; pidx = int'(mem_req_addr[7:2]); reqs++;
      end
    end
  end

  // data mover model: records each accepted request, pulses done DLY cycles later
  initial begin
    forever begin
      @(negedge clk);
      xfer_done = 1'b0;
      if (dcnt > 0) begin
        dcnt--;
        if (dcnt == 0) begin
          xfer_done = 1'b1;
          if (reqs != reqs_acc) viol++;
        end
      end
      xfer_ready = stall ? ~xfer_ready : 1'b1;
      if (xfer_valid && xfer_ready) begin
        g_dst[nx] = xfer_dst; g_src[nx] = xfer_src; g_x[nx] = xfer_x_len;
        g_y[nx] = xfer_y_len; g_ss[nx] = xfer_src_stride; g_ds[nx] = xfer_dst_stride;
        g_id[nx] = xfer_id; nx++; reqs_acc = reqs; dcnt = DLY;
      end
      if (cpl_valid) begin c_id[ncpl] = cpl_id; ncpl++; end
    end
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int r0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(12'h408, s);
    chk("R1 status", s, 0);
    chk("R1 outputs", {mem_req_valid, xfer_valid, cpl_valid, irq}, 0);

    // R10 cyclic gating
    wr(12'h400, 32'h2); chk("R10 cyclic allowed", cyclic_en, 1);
    wr(12'h400, 32'h3); chk("R10 cyclic blocked", cyclic_en, 0);

    // R2 submit with descriptor mode clear
    for (int i = 0; i < 4; i++)
      load_desc(i*12, TBL[i], (i < 3) ? 64'((i+1)*48) : 64'hFFFF_FFFF_FFFF_FFF0);
    wr(12'h47C, 32'h0); wr(12'h480, 32'h0);
    wr(12'h400, 32'h0); wr(12'h404, 32'h1);
    repeat (10) @(negedge clk);
    rd(12'h408, s);
    chk("R2 no fetch without mode", reqs, 0);
    chk("R2 stays idle", s[0], 0);

    // main chain with back-pressure on both channels
    stall = 1;
    wr(12'h400, 32'h1); wr(12'h404, 32'h1);
    rd(12'h408, s); chk("R11 busy after submit", s[0], 1);
    for (int i = 0; i < 2000 && nx == 0; i++) @(negedge clk);
    wr(12'h404, 32'h1); // R2 submit while busy is ignored
    wait_idle();
    stall = 0;
    repeat (DLY + 4) @(negedge clk);
    chk("R6 transfers in chain", nx, 4);
    chk("R3 R6 words fetched", reqs, 48);
    chk("R5 no fetch before done", viol, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R4 dst", g_dst[i], TBL[i].dst);
      chk("R4 src", g_src[i], TBL[i].src);
      chk("R4 x len", g_x[i], TBL[i].x);
      chk("R4 y len", g_y[i], TBL[i].y);
      chk("R4 strides", {g_ss[i], g_ds[i]}, {TBL[i].ss, TBL[i].ds});
      chk("R4 id", g_id[i], TBL[i].id);
      chk("R7 completion id", c_id[i], TBL[i].id);
    end
    rd(12'h40C, s); chk("R7 last id", s, 32'h44);
    rd(12'h408, s); chk("R8 pending bit", s[2], 1);
    chk("R8 irq out", irq, 1);
    wr(12'h408, 32'h4);
    chk("R8 irq cleared", irq, 0);

    // R9 read error on word 5 of the first descriptor
    r0 = reqs; err_word = 5;
    wr(12'h404, 32'h1);
    wait_idle();
    repeat (4) @(negedge clk);
    rd(12'h408, s);
    chk("R9 error bit", s[1], 1);
    chk("R9 idle", s[0], 0);
    chk("R9 no transfer", nx, 4);
    chk("R9 fetch stopped", reqs - r0, 6);
    wr(12'h408, 32'h2);
    rd(12'h408, s); chk("R9 error cleared", s[1], 0);
    err_word = -1;

    // single last descriptor, no interrupt flag, garbage next pointer
    load_desc(48, '{2'b01, 32'h55, 64'h10, 64'h20, 32'd0, 32'h7, 32'd0, 32'd0}, 64'h0);
    r0 = reqs;
    wr(12'h47C, 32'd192); wr(12'h404, 32'h1);
    wait_idle();
    repeat (DLY + 4) @(negedge clk);
    chk("R6 single words", reqs - r0, 12);
    chk("R6 single transfer", nx, 5);
    chk("R7 single cpl", c_id[4], 32'h55);
    chk("R8 no irq without flag", irq, 0);
    rd(12'h408, s); chk("R11 idle at end", s[0], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule